// File: doc/BRIEF.md
# In-Place Radix-2 FFT Address Sequencer

This block steers a memory-based, in-place, decimation-in-frequency radix-2 FFT of N = 2^M points. It produces no arithmetic of its own. It drives a single memory address, read and write strobes, a twiddle exponent and a rotation flag. An external datapath, a twiddle table and a data memory follow these signals. A transform runs in three phases after a start request: loading, computing and draining.

During loading, N samples are written to memory at addresses 0 to N-1 in order. Computing walks M stages. Each stage takes N/4 steps, and each step serves two butterflies at once. Those two butterflies sit N/4 butterflies apart in the stage, so they always share one twiddle exponent. Each step reads four words, waits for the datapath latency, and then writes the four results back to the same addresses. During draining, N words are read out in bit-reversed address order, which puts the spectrum in natural order. A one-cycle done pulse closes the run.

In the first stage, the second butterfly of a pair needs the shared twiddle multiplied by -j. The sequencer signals this with a flag instead of issuing a second exponent.

Top module: `fft_seq`

## Requirements
- R1: After reset, and whenever no transform is running, mem_rd, mem_wr, rot_j, busy and done are 0, and mem_addr and tw_exp are 0.
- R2: If start is high at a clock edge while the sequencer is idle, the next N cycles each assert mem_wr alone, with mem_addr = 0, 1, ..., N-1 in ascending order.
- R3: The compute phase has M stages (s = 1..M), each with N/4 steps (m = 0..N/4-1), taken in that nested order. Each step lasts exactly LAT+8 cycles: 4 read cycles, then LAT cycles with neither strobe and mem_addr 0, then 4 write cycles.
- R4: In stage s, let Ns = N >> s. The base address of butterfly b is (b / Ns)·2·Ns + (b mod Ns). Step m serves butterflies b1 = m and b2 = m + N/4, with bases k1 and k2. Its reads address k1, k1+Ns, k2, k2+Ns in that order, and its writes use the same four addresses in the same order.
- R5: For every cycle of step m in stage s, tw_exp = (m mod Ns)·2^(s-1). Outside the compute phase, tw_exp is 0.
- R6: rot_j is 1 on every cycle of every stage-1 step and 0 at all other times.
- R7: After the compute phase, the next N cycles each assert mem_rd alone, with mem_addr equal to the M-bit bit-reversal of a count running 0..N-1.
- R8: busy is 1 from the first load cycle through the last drain read. In the cycle after the last drain read, done is 1 and busy is 0. done is never high for two cycles in a row.
- R9: start while busy has no effect. The running sequence continues unchanged.
- R10: A start raised during the done cycle is accepted, and the next cycle is the first load write.
- R11: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a transform (taken only when idle) |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle end-of-transform pulse |
| mem_addr | output | M | Data memory word address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| tw_exp | output | M-1 | Twiddle exponent p of W^p, W = exp(-j2π/N) |
| rot_j | output | 1 | Second butterfly uses twiddle times -j |

## Verification
Every cycle is compared with a model that builds the full expected sequence from the index formulas, using integer division and modulo. The check runs across every stage, so a mix-up between the address terms that change per stage (group stride, offset, Ns) and the exponent scaling shows up as soon as its stage arrives. Start pulses inside the load, compute and drain phases separate a correct ignore from a restart. A start in the done cycle checks back-to-back acceptance. Reset is applied in the middle of a run and compared against the idle state.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_COMP  = 2'd2,
        PH_DRAIN = 2'd3
    } phase_t;
endpackage

// File: rtl/fft_seq_bitrev.sv
module fft_seq_bitrev #(
    parameter int W = 4
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/fft_seq_agen.sv
module fft_seq_agen #(
    parameter int M  = 4,
    parameter int SW = 3
) (
    input  logic [SW-1:0]       stage,
    input  logic [M-3:0]        iter,
    output logic [3:0][M-1:0]   addr,
    output logic [M-2:0]        tw
);
    localparam int N = 1 << M;
    localparam int Q = N / 4;

    int         sh;
    int         sm1;
    logic [M:0] b1, b2, mask, ns, k1, k2, off;

    always_comb begin
        // stage 0 only occurs outside the compute phase; treat it as stage 1
        if (stage == '0) begin
            sh  = M - 1;
            sm1 = 0;
        end else begin
            sh  = M - int'(stage);
            sm1 = int'(stage) - 1;
        end
        ns   = (M+1)'(1) << sh;
        mask = ns - (M+1)'(1);
        b1   = (M+1)'(iter);
        b2   = b1 + (M+1)'(Q);
        k1   = ((b1 >> sh) << (sh + 1)) | (b1 & mask);
        k2   = ((b2 >> sh) << (sh + 1)) | (b2 & mask);
        off  = (b1 & mask) << sm1;
        addr[0] = M'(k1);
        addr[1] = M'(k1 + ns);
        addr[2] = M'(k2);
        addr[3] = M'(k2 + ns);
        tw      = off[M-2:0];
    end
endmodule

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl
    import fft_seq_pkg::*;
#(
    parameter int M   = 4,
    parameter int LAT = 2,
    parameter int SW  = 3,
    parameter int LW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output phase_t        phase,
    output logic [M-1:0]  cnt,
    output logic [SW-1:0] stage,
    output logic [M-3:0]  iter,
    output logic [LW-1:0] slot,
    output logic          done
);
    localparam int N = 1 << M;
    localparam int Q = N / 4;
    localparam logic [M-1:0]  CNT_LAST  = M'(N - 1);
    localparam logic [M-3:0]  ITER_LAST = (M-2)'(Q - 1);
    localparam logic [SW-1:0] STG_LAST  = SW'(M);
    localparam logic [LW-1:0] SLOT_LAST = LW'(LAT + 7);

    typedef struct packed {
        phase_t        phase;
        logic [M-1:0]  cnt;
        logic [SW-1:0] stage;
        logic [M-3:0]  iter;
        logic [LW-1:0] slot;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_LOAD;
                    st_d.cnt   = '0;
                end
            end
            PH_LOAD: begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.phase = PH_COMP;
                    st_d.cnt   = '0;
                    st_d.stage = SW'(1);
                    st_d.iter  = '0;
                    st_d.slot  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_COMP: begin
                if (st_q.slot == SLOT_LAST) begin
                    st_d.slot = '0;
                    if (st_q.iter == ITER_LAST) begin
                        st_d.iter = '0;
                        if (st_q.stage == STG_LAST) begin
                            st_d.phase = PH_DRAIN;
                            st_d.stage = '0;
                            st_d.cnt   = '0;
                        end else begin
                            st_d.stage = st_q.stage + 1'b1;
                        end
                    end else begin
                        st_d.iter = st_q.iter + 1'b1;
                    end
                end else begin
                    st_d.slot = st_q.slot + 1'b1;
                end
            end
            PH_DRAIN: begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, stage: '0, iter: '0, slot: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign cnt   = st_q.cnt;
    assign stage = st_q.stage;
    assign iter  = st_q.iter;
    assign slot  = st_q.slot;
    assign done  = st_q.done;
endmodule

// File: rtl/fft_seq.sv
module fft_seq
    import fft_seq_pkg::*;
#(
    parameter int M   = 4,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] mem_addr,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic [M-2:0] tw_exp,
    output logic         rot_j
);
    localparam int SW = $clog2(M + 1);
    localparam int LW = $clog2(LAT + 8);
    localparam logic [LW-1:0] WR_FIRST = LW'(LAT + 4);

    phase_t             phase;
    logic [M-1:0]       cnt;
    logic [M-1:0]       cnt_rev;
    logic [SW-1:0]      stage;
    logic [M-3:0]       iter;
    logic [LW-1:0]      slot;
    logic [3:0][M-1:0]  quad;
    logic [M-2:0]       tw;
    logic [LW-1:0]      wslot;
    logic               in_rd, in_wr;

    fft_seq_ctrl #(.M(M), .LAT(LAT), .SW(SW), .LW(LW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .phase (phase),
        .cnt   (cnt),
        .stage (stage),
        .iter  (iter),
        .slot  (slot),
        .done  (done)
    );

    fft_seq_agen #(.M(M), .SW(SW)) u_agen (
        .stage (stage),
        .iter  (iter),
        .addr  (quad),
        .tw    (tw)
    );

    fft_seq_bitrev #(.W(M)) u_rev (
        .din  (cnt),
        .dout (cnt_rev)
    );

    always_comb begin
        in_rd    = (phase == PH_COMP) && (slot < LW'(4));
        in_wr    = (phase == PH_COMP) && (slot >= WR_FIRST);
        wslot    = slot - WR_FIRST;
        busy     = (phase != PH_IDLE);
        mem_rd   = in_rd || (phase == PH_DRAIN);
        mem_wr   = in_wr || (phase == PH_LOAD);
        rot_j    = (phase == PH_COMP) && (stage == SW'(1));
        tw_exp   = (phase == PH_COMP) ? tw : '0;
        mem_addr = '0;
        unique case (phase)
            PH_LOAD:  mem_addr = cnt;
            PH_DRAIN: mem_addr = cnt_rev;
            PH_COMP: begin
                if (in_rd)      mem_addr = quad[slot[1:0]];
                else if (in_wr) mem_addr = quad[wslot[1:0]];
            end
            default:  mem_addr = '0;
        endcase
    end
endmodule

// File: rtl/fft_seq_chk.sv
module fft_seq_chk #(
    parameter int M = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [M-1:0] mem_addr,
    input logic         mem_rd,
    input logic         mem_wr,
    input logic [M-2:0] tw_exp,
    input logic         rot_j
);
    assert_excl_rw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_load_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_wr && mem_addr == '0));

    assert_rot_scope_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rot_j |-> (busy && !done));

    assert_tw_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tw_exp == '0));

    assert_strobe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !rot_j));
endmodule

bind fft_seq fft_seq_chk #(.M(M)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .tw_exp   (tw_exp),
    .rot_j    (rot_j)
);

// File: tb/tb_fft_seq.sv
module tb_fft_seq;
    localparam int M      = 4;
    localparam int LAT    = 2;
    localparam int N      = 1 << M;
    localparam int Q      = N / 4;
    localparam int PERIOD = 10;

    typedef struct {
        bit    rd, wr, busy, done, rot;
        int    addr, tw;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         busy, done, mem_rd, mem_wr, rot_j;
    logic [M-1:0] mem_addr;
    logic [M-2:0] tw_exp;

    int   errors = 0;
    int   checks = 0;
    exp_t q[$];

    always #(PERIOD/2) clk = ~clk;

    fft_seq #(.M(M), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .tw_exp(tw_exp), .rot_j(rot_j)
    );

    function automatic exp_t mk(bit rd, bit wr, bit bz, bit dn, bit rt, int a, int t, string tg);
        exp_t e;
        e.rd = rd; e.wr = wr; e.busy = bz; e.done = dn; e.rot = rt;
        e.addr = a; e.tw = t; e.tag = tg;
        return e;
    endfunction

    function automatic int base_of(int b, int ns);
        return (b / ns) * 2 * ns + (b % ns);
    endfunction

    function automatic int rev_of(int v);
        int r = 0;
        for (int i = 0; i < M; i++) if (v[i]) r |= 1 << (M - 1 - i);
        return r;
    endfunction

    task automatic push_run(string first_tag);
        int a[4];
        for (int i = 0; i < N; i++)
            q.push_back(mk(0, 1, 1, 0, 0, i, 0, (i == 0) ? first_tag : "R2"));
        for (int s = 1; s <= M; s++) begin
            int ns = N >> s;
            for (int m = 0; m < Q; m++) begin
                int p  = (m % ns) * (1 << (s - 1));
                bit rt = (s == 1);
                a[0] = base_of(m, ns);
                a[1] = a[0] + ns;
                a[2] = base_of(m + Q, ns);
                a[3] = a[2] + ns;
                for (int k = 0; k < 4; k++)   q.push_back(mk(1, 0, 1, 0, rt, a[k], p, "R4"));
                for (int k = 0; k < LAT; k++) q.push_back(mk(0, 0, 1, 0, rt, 0, p, "R3"));
                for (int k = 0; k < 4; k++)   q.push_back(mk(0, 1, 1, 0, rt, a[k], p, "R4"));
            end
        end
        for (int i = 0; i < N; i++)
            q.push_back(mk(1, 0, 1, 0, 0, rev_of(i), 0, "R7"));
        q.push_back(mk(0, 0, 0, 1, 0, 0, 0, "R8"));
    endtask

    task automatic chk(string tg, bit ok, string act, string ex);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s at %0t", tg, act, ex, $time);
        end
    endtask

    task automatic compare(exp_t e, string override);
        string tg = (override != "") ? override : e.tag;
        string act, ex;
        act = $sformatf("rd=%0d wr=%0d addr=%0d busy=%0d done=%0d", mem_rd, mem_wr, mem_addr, busy, done);
        ex  = $sformatf("rd=%0d wr=%0d addr=%0d busy=%0d done=%0d", e.rd, e.wr, e.addr, e.busy, e.done);
        chk(tg, mem_rd == e.rd && mem_wr == e.wr && int'(mem_addr) == e.addr, act, ex);
        chk("R8", busy == e.busy && done == e.done, act, ex);
        chk("R5", int'(tw_exp) == e.tw, $sformatf("tw=%0d", tw_exp), $sformatf("tw=%0d", e.tw));
        chk("R6", rot_j == e.rot, $sformatf("rot=%0d", rot_j), $sformatf("rot=%0d", e.rot));
        chk("R11", !(mem_rd && mem_wr), $sformatf("rd=%0d wr=%0d", mem_rd, mem_wr), "not both");
    endtask

    task automatic step(bit drive_start, string first_tag, output bit saw_done);
        exp_t e;
        string ov = "";
        @(negedge clk);
        if (q.size() != 0) e = q.pop_front();
        else               e = mk(0, 0, 0, 0, 0, 0, 0, "R1");
        if (e.tag == "R4" && e.addr < 0) ov = "R3";
        compare(e, ov);
        saw_done = e.done;
        start = drive_start;
        if (drive_start && q.size() == 0) push_run(first_tag);
    endtask

    initial begin
        bit dn;
        int run_len = N + M * Q * (LAT + 8) + N + 1;
        repeat (2) begin
            @(negedge clk);
            compare(mk(0, 0, 0, 0, 0, 0, 0, "R1"), "R1");
        end
        rst_n = 1'b1;
        repeat (3) step(0, "", dn);
        step(1, "R2", dn);
        step(0, "", dn);
        for (int c = 0; c < run_len + 4; c++) begin
            bit ign = (c == 5) || (c == 60) || (c == run_len - 6);
            step(ign, "", dn);
            if (ign) begin
                // R9: the ignored request must leave the next cycle on the planned sequence
                @(negedge clk);
                start = 1'b0;
                if (q.size() != 0) compare(q.pop_front(), "R9");
            end
            if (dn) begin
                // R10: request during the done cycle starts a fresh run
                start = 1'b1;
                push_run("R10");
                break;
            end
        end
        step(0, "", dn);
        for (int c = 0; c < run_len + 4; c++) step(0, "", dn);
        chk("R8", q.size() == 0, $sformatf("left=%0d", q.size()), "left=0");
        // reset in the middle of a third run returns to idle
        step(1, "R2", dn);
        repeat (30) step(0, "", dn);
        rst_n = 1'b0;
        q.delete();
        #1;
        compare(mk(0, 0, 0, 0, 0, 0, 0, "R1"), "R1");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) step(0, "", dn);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule